// File: doc/BRIEF.md
# Spiking Neuron Update Lane

This block is one datapath lane of a spiking neural network engine. It receives a 72-bit state word that packs two signed 36-bit membrane potentials, along with a 32-bit synapse entry. It returns the rewritten word and a spike flag one clock later. The surrounding engine owns the state memory, the scan order and the delivery of synapse entries. It feeds this lane one word per cycle and writes the result back.

Two kinds of step are supported, chosen per transaction.

- **Baseline step.** Once per timestep, the lane applies the selected neuron dynamics to both potentials in the word. Any potential already above the threshold is cleared instead.
- **Synaptic step.** The lane adds the entry's sign-extended weight to the one potential that the entry addresses. The other half of the word passes through unchanged.

In both steps the spike flag reports whether the addressed potential, as presented at the input, exceeds the threshold.

Top module: `neuron_update_lane`

## Requirements
- R1: With `model_sel` = 0 (memoryless), a baseline step writes 0 into every half whose potential does not exceed the threshold.
- R2: In a baseline step, any half whose potential is strictly greater than the signed threshold becomes 0 whatever the model. A potential equal to the threshold is not reset.
- R3: With `model_sel` = 1 (incremental), a baseline step adds `group_idx` + 1 to each half that is not over threshold, so group 0 adds 1 and group 15 adds 16.
- R4: With `model_sel` = 2 (leaky), a baseline step replaces V with V − (V >>> 3), using an arithmetic shift, for negative values too.
- R5: With `model_sel` = 3 (non-leaky), a baseline step leaves a potential that is not over threshold unchanged.
- R6: In a synaptic step (`step_sel` = 1), the field `syn_entry[15:0]` is read as a signed 16-bit weight. It is sign-extended to 36 bits and added to the addressed potential. The reserved bits 30:29 and the address bits 28:17 have no effect.
- R7: When `syn_entry[31]` (null flag) is 1, the weight is taken as 0 and the synaptic step returns the word unchanged.
- R8: Synaptic addition does not saturate; a result outside the 36-bit signed range wraps in two's complement.
- R9: `syn_entry[16]` (target address bit 0) selects the half in both steps: 0 selects bits 35:0 and 1 selects bits 71:36. A synaptic step leaves the unselected half unchanged, while a baseline step updates both halves.
- R10: `spike_out` is 1 exactly when the selected half of the input word is strictly greater than `threshold`, in both steps. A synaptic step never resets the potential.
- R11: `out_valid` rises on the clock edge after an edge that samples `in_valid` = 1, and `word_out` and `spike_out` carry that transaction's result in the same cycle.
- R12: A cycle without `in_valid` gives `out_valid` = 0 on the next edge and leaves `word_out` and `spike_out` unchanged.
- R13: While `rst_n` is low at a clock edge, `out_valid`, `word_out` and `spike_out` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Transaction present on the inputs |
| step_sel | input | 1 | 0 = baseline step, 1 = synaptic step |
| model_sel | input | 2 | Dynamics: 0 memoryless, 1 incremental, 2 leaky, 3 non-leaky |
| threshold | input | 36 | Signed firing threshold |
| group_idx | input | 4 | Index of the lane's neuron group (sets the increment) |
| word_in | input | 72 | Two packed signed potentials, half 1 in bits 71:36 |
| syn_entry | input | 32 | Null flag, reserved, target address, signed weight |
| out_valid | output | 1 | Result registered this cycle |
| word_out | output | 72 | Updated packed word |
| spike_out | output | 1 | Selected input potential was above threshold |

## Verification
Each of the four dynamics is driven with both positive and negative potentials in the two halves. This separates an arithmetic shift from a logical one and shows that the baseline step touches both halves. The threshold patterns place a potential one above, exactly at, and below positive and negative thresholds, which isolates the strict comparison and the reset priority. The synaptic patterns use the extreme weights, a null entry carrying a non-zero weight, set reserved bits, and both half selects, so that sign extension, masking and pass-through are each observed on their own. Potentials at the 36-bit limits expose saturation versus wrap, and idle gaps with changing inputs show whether the output register is held.

// File: rtl/neuron_lane_pkg.sv
// Package: shared enumerations for the neuron update lane.
// Assumes: the step and model encodings are fixed by the lane's interface.
package neuron_lane_pkg;

    typedef enum logic [1:0] {
        MDL_ZERO = 2'd0,
        MDL_INCR = 2'd1,
        MDL_LEAK = 2'd2,
        MDL_HOLD = 2'd3
    } model_e;

    typedef enum logic {
        STEP_BASE = 1'b0,
        STEP_SYN  = 1'b1
    } step_e;

endpackage

// File: rtl/nl_syn_decode.sv
// Module: nl_syn_decode
// Splits a synapse entry into a sign-extended (or null-forced) weight and the
// half-select bit (target address bit 0).
// Assumes: the null flag is the top bit and the address field sits directly
// above the weight field.
module nl_syn_decode #(
    parameter int ENTRY_W  = 32,
    parameter int WEIGHT_W = 16,
    parameter int POT_W    = 36
) (
    input  logic [ENTRY_W-1:0]      entry,
    output logic signed [POT_W-1:0] weight_ext,
    output logic                    hi_sel
);
    localparam int NULL_BIT = ENTRY_W - 1;
    localparam int SEL_BIT  = WEIGHT_W;
    localparam int EXT_W    = POT_W - WEIGHT_W;

    logic [WEIGHT_W-1:0] raw_weight;
    logic                unused_fields;

    assign raw_weight    = entry[WEIGHT_W-1:0];
    assign unused_fields = ^entry[NULL_BIT-1:SEL_BIT+1];

    // Purpose: widen the weight with its sign bit, or zero it when null.
    always_comb begin
        if (entry[NULL_BIT])
            weight_ext = '0;
        else
            weight_ext = $signed({{EXT_W{raw_weight[WEIGHT_W-1]}}, raw_weight});
    end

    assign hi_sel = entry[SEL_BIT];

endmodule

// File: rtl/nl_pot_update.sv
// Module: nl_pot_update
// Computes the next value of one membrane potential for either step kind.
// Assumes: arithmetic wraps at POT_W bits; threshold comparison is signed.
module nl_pot_update
    import neuron_lane_pkg::*;
#(
    parameter int POT_W      = 36,
    parameter int GRP_W      = 4,
    parameter int LEAK_SHIFT = 3
) (
    input  step_e                   step,
    input  model_e                  model,
    input  logic signed [POT_W-1:0] pot,
    input  logic signed [POT_W-1:0] thr,
    input  logic [GRP_W-1:0]        grp,
    input  logic signed [POT_W-1:0] weight_ext,
    input  logic                    targeted,
    output logic signed [POT_W-1:0] new_pot
);
    logic [POT_W-1:0]        incr_amt;
    logic signed [POT_W-1:0] model_res;
    logic signed [POT_W-1:0] base_res;
    logic signed [POT_W-1:0] syn_res;

    assign incr_amt = POT_W'(grp) + POT_W'(1);

    // Purpose: evaluate the selected dynamics on the current potential.
    always_comb begin
        unique case (model)
            MDL_ZERO: model_res = '0;
            MDL_INCR: model_res = pot + $signed(incr_amt);
            MDL_LEAK: model_res = pot - (pot >>> LEAK_SHIFT);
            default:  model_res = pot;
        endcase
    end

    // Purpose: pick the baseline or synaptic result, with threshold reset first.
    always_comb begin
        base_res = (pot > thr) ? '0 : model_res;
        syn_res  = targeted ? (pot + weight_ext) : pot;
        new_pot  = (step == STEP_SYN) ? syn_res : base_res;
    end

endmodule

// File: rtl/neuron_update_lane.sv
// Module: neuron_update_lane
// One registered lane: unpacks two potentials, updates each, detects a spike
// on the selected half and registers the result with one cycle of latency.
// Assumes: the caller writes word_out back to state memory itself.
module neuron_update_lane
    import neuron_lane_pkg::*;
#(
    parameter int POT_W    = 36,
    parameter int NUM_HALF = 2,
    parameter int GRP_W    = 4,
    parameter int ENTRY_W  = 32,
    parameter int WEIGHT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      step_sel,
    input  logic [1:0]                model_sel,
    input  logic [POT_W-1:0]          threshold,
    input  logic [GRP_W-1:0]          group_idx,
    input  logic [NUM_HALF*POT_W-1:0] word_in,
    input  logic [ENTRY_W-1:0]        syn_entry,
    output logic                      out_valid,
    output logic [NUM_HALF*POT_W-1:0] word_out,
    output logic                      spike_out
);
    localparam int WORD_W = NUM_HALF * POT_W;

    logic signed [POT_W-1:0] weight_ext;
    logic                    hi_sel;
    logic signed [POT_W-1:0] thr_s;
    logic [WORD_W-1:0]       word_nxt;
    logic signed [POT_W-1:0] sel_pot;
    logic                    spike_nxt;
    step_e                   step;
    model_e                  model;

    assign thr_s = $signed(threshold);
    assign step  = step_e'(step_sel);
    assign model = model_e'(model_sel);

    nl_syn_decode #(
        .ENTRY_W (ENTRY_W),
        .WEIGHT_W(WEIGHT_W),
        .POT_W   (POT_W)
    ) i_decode (
        .entry     (syn_entry),
        .weight_ext(weight_ext),
        .hi_sel    (hi_sel)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        logic signed [POT_W-1:0] pot_new;

        nl_pot_update #(
            .POT_W(POT_W),
            .GRP_W(GRP_W)
        ) i_upd (
            .step      (step),
            .model     (model),
            .pot       ($signed(word_in[h*POT_W +: POT_W])),
            .thr       (thr_s),
            .grp       (group_idx),
            .weight_ext(weight_ext),
            .targeted  (hi_sel == 1'(h)),
            .new_pot   (pot_new)
        );

        assign word_nxt[h*POT_W +: POT_W] = pot_new;
    end

    // Purpose: compare the addressed input potential against the threshold.
    always_comb begin
        sel_pot   = $signed(word_in[(hi_sel ? POT_W : 0) +: POT_W]);
        spike_nxt = sel_pot > thr_s;
    end

    // Purpose: output register; holds word and flag when no transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            word_out  <= '0;
            spike_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                word_out  <= word_nxt;
                spike_out <= spike_nxt;
            end
        end
    end

endmodule

// File: rtl/nl_lane_checker.sv
// Module: nl_lane_checker
// Temporal properties of the lane, attached to every instance by bind.
// Assumes: a two-half word and the default synapse entry layout.
module nl_lane_checker #(
    parameter int POT_W    = 36,
    parameter int ENTRY_W  = 32,
    parameter int WEIGHT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 step_sel,
    input logic [POT_W-1:0]     threshold,
    input logic [2*POT_W-1:0]   word_in,
    input logic [ENTRY_W-1:0]   syn_entry,
    input logic                 out_valid,
    input logic [2*POT_W-1:0]   word_out,
    input logic                 spike_out
);
    logic                    sel_hi;
    logic signed [POT_W-1:0] in_sel;
    logic                    in_over;
    logic [POT_W-1:0]        out_lo;
    logic [POT_W-1:0]        out_hi;

    assign sel_hi  = syn_entry[WEIGHT_W];
    assign in_sel  = sel_hi ? $signed(word_in[2*POT_W-1:POT_W]) : $signed(word_in[POT_W-1:0]);
    assign in_over = in_sel > $signed(threshold);
    assign out_lo  = word_out[POT_W-1:0];
    assign out_hi  = word_out[2*POT_W-1:POT_W];

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r12_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(word_out) && $stable(spike_out)));

    a_r10_spike_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (spike_out == $past(in_over)));

    a_r2_reset_on_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !step_sel && in_over) |=>
            (($past(sel_hi) ? out_hi : out_lo) == '0));

    a_r7_null_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && step_sel && syn_entry[ENTRY_W-1]) |=> (word_out == $past(word_in)));

    a_r9_other_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && step_sel) |=>
            ($past(sel_hi) ? (out_lo == $past(word_in[POT_W-1:0]))
                           : (out_hi == $past(word_in[2*POT_W-1:POT_W]))));

endmodule

bind neuron_update_lane nl_lane_checker #(
    .POT_W   (POT_W),
    .ENTRY_W (ENTRY_W),
    .WEIGHT_W(WEIGHT_W)
) i_lane_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .step_sel (step_sel),
    .threshold(threshold),
    .word_in  (word_in),
    .syn_entry(syn_entry),
    .out_valid(out_valid),
    .word_out (word_out),
    .spike_out(spike_out)
);

// File: tb/test_neuron_update_lane.sv
// Directed bench for neuron_update_lane: one task per scenario.
module test_neuron_update_lane;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic               step_sel;
    logic [1:0]         model_sel;
    logic [35:0]        threshold;
    logic [3:0]         group_idx;
    logic [71:0]        word_in;
    logic [31:0]        syn_entry;
    logic               out_valid;
    logic [71:0]        word_out;
    logic               spike_out;

    int checks   = 0;
    int failures = 0;

    logic [71:0] got_word;
    logic        got_spike;
    logic        got_valid;

    always #5 clk = ~clk;

    neuron_update_lane i_neuron_update_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .step_sel (step_sel),
        .model_sel(model_sel),
        .threshold(threshold),
        .group_idx(group_idx),
        .word_in  (word_in),
        .syn_entry(syn_entry),
        .out_valid(out_valid),
        .word_out (word_out),
        .spike_out(spike_out)
    );

    function automatic logic [71:0] pk(input logic [35:0] hi, input logic [35:0] lo);
        return {hi, lo};
    endfunction

    task automatic chk_word(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s word actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s bit actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One transaction: drive at negedge, sample just after the capturing edge.
    task automatic drive(input logic st, input logic [1:0] m, input logic [35:0] thr,
                         input logic [3:0] g, input logic [71:0] w, input logic [31:0] s);
        @(negedge clk);
        step_sel  = st;
        model_sel = m;
        threshold = thr;
        group_idx = g;
        word_in   = w;
        syn_entry = s;
        in_valid  = 1'b1;
        @(posedge clk);
        #1;
        got_word  = word_out;
        got_spike = spike_out;
        got_valid = out_valid;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; step_sel = 1'b0; model_sel = 2'd3;
        threshold = 36'sd0; group_idx = 4'd0; word_in = {72{1'b1}}; syn_entry = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_bit("R13 valid", out_valid, 1'b0);
        chk_word("R13 word", word_out, '0);
        chk_bit("R13 spike", spike_out, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_memoryless;
        drive(1'b0, 2'd0, 36'sd1000, 4'd3, pk(-36'sd5, 36'sd100), 32'h0);
        chk_bit("R11 valid after input", got_valid, 1'b1);
        chk_word("R1 memoryless", got_word, pk(36'sd0, 36'sd0));
        chk_bit("R10 no spike", got_spike, 1'b0);
    endtask

    task automatic t_threshold;
        drive(1'b0, 2'd3, 36'sd1000, 4'd0, pk(36'sd50, 36'sd1001), 32'h0);
        chk_word("R2 above resets lo", got_word, pk(36'sd50, 36'sd0));
        chk_bit("R10 spike lo", got_spike, 1'b1);
        drive(1'b0, 2'd3, 36'sd1000, 4'd0, pk(36'sd2000, 36'sd1000), 32'h0001_0000);
        chk_word("R2 equal kept, hi reset", got_word, pk(36'sd0, 36'sd1000));
        chk_bit("R9 R10 spike uses hi", got_spike, 1'b1);
        drive(1'b0, 2'd3, 36'sd1000, 4'd0, pk(36'sd1000, 36'sd1000), 32'h0);
        chk_bit("R10 equal no spike", got_spike, 1'b0);
        drive(1'b0, 2'd1, -36'sd10, 4'd2, pk(-36'sd20, -36'sd5), 32'h0);
        chk_word("R2 negative threshold", got_word, pk(-36'sd17, 36'sd0));
        chk_bit("R10 negative threshold spike", got_spike, 1'b1);
    endtask

    task automatic t_incremental;
        drive(1'b0, 2'd1, 36'sd1000, 4'd0, pk(-36'sd3, 36'sd5), 32'h0);
        chk_word("R3 group0 +1", got_word, pk(-36'sd2, 36'sd6));
        drive(1'b0, 2'd1, 36'sd1000, 4'd15, pk(-36'sd3, 36'sd5), 32'h0);
        chk_word("R3 group15 +16", got_word, pk(36'sd13, 36'sd21));
    endtask

    task automatic t_leaky;
        drive(1'b0, 2'd2, 36'sd1000, 4'd0, pk(-36'sd80, 36'sd80), 32'h0);
        chk_word("R4 leak +/-80", got_word, pk(-36'sd70, 36'sd70));
        drive(1'b0, 2'd2, 36'sd1000, 4'd0, pk(36'sd7, -36'sd1), 32'h0);
        chk_word("R4 leak -1 and 7", got_word, pk(36'sd7, 36'sd0));
    endtask

    task automatic t_hold_model;
        drive(1'b0, 2'd3, 36'sd1000, 4'd9, pk(-36'sd123456, 36'sd999), 32'h0);
        chk_word("R5 non-leaky", got_word, pk(-36'sd123456, 36'sd999));
    endtask

    task automatic t_synaptic;
        drive(1'b1, 2'd0, 36'sd1000, 4'd0, pk(36'sd77, 36'sd10), 32'h0000_FFFD);
        chk_word("R6 R9 weight -3 lo", got_word, pk(36'sd77, 36'sd7));
        drive(1'b1, 2'd0, 36'sd1000, 4'd0, pk(36'sd77, 36'sd10), 32'h6001_7FFF);
        chk_word("R6 R9 weight max hi, reserved ignored", got_word, pk(36'sd32844, 36'sd10));
        chk_bit("R10 no spike hi", got_spike, 1'b0);
        drive(1'b1, 2'd0, 36'sd1000, 4'd0, pk(36'sd0, 36'sd10), 32'h0001_8000);
        chk_word("R6 weight min hi", got_word, pk(-36'sd32768, 36'sd10));
        drive(1'b1, 2'd0, 36'sd50, 4'd0, pk(36'sd0, 36'sd60), 32'h0000_0001);
        chk_word("R10 synaptic no reset", got_word, pk(36'sd0, 36'sd61));
        chk_bit("R10 synaptic spike", got_spike, 1'b1);
    endtask

    task automatic t_null;
        drive(1'b1, 2'd1, 36'sd1000, 4'd0, pk(36'sd77, 36'sd10), 32'h8001_1234);
        chk_word("R7 null hi", got_word, pk(36'sd77, 36'sd10));
        drive(1'b1, 2'd1, 36'sd1000, 4'd0, pk(36'sd77, 36'sd10), 32'h8000_FFFF);
        chk_word("R7 null lo", got_word, pk(36'sd77, 36'sd10));
    endtask

    task automatic t_wrap;
        drive(1'b1, 2'd0, 36'h7_FFFF_FFFF, 4'd0, pk(36'sd4, 36'h7_FFFF_FFFF), 32'h0000_0001);
        chk_word("R8 positive wrap", got_word, pk(36'sd4, 36'h8_0000_0000));
        chk_bit("R10 max not above max", got_spike, 1'b0);
        drive(1'b1, 2'd0, 36'h7_FFFF_FFFF, 4'd0, pk(36'h8_0000_0000, 36'sd4), 32'h0001_FFFF);
        chk_word("R8 negative wrap", got_word, pk(36'h7_FFFF_FFFF, 36'sd4));
    endtask

    task automatic t_idle_hold;
        logic [71:0] kept;
        drive(1'b0, 2'd3, 36'sd10, 4'd0, pk(36'sd3, 36'sd20), 32'h0);
        kept = got_word;
        chk_bit("R10 spike before idle", got_spike, 1'b1);
        word_in   = pk(36'sd555, 36'sd1);
        syn_entry = 32'h0001_0000;
        step_sel  = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk_bit("R12 idle valid low", out_valid, 1'b0);
        chk_word("R12 idle word held", word_out, kept);
        chk_bit("R12 idle spike held", spike_out, 1'b1);
    endtask

    task automatic t_mid_reset;
        drive(1'b0, 2'd3, 36'sd0, 4'd0, pk(36'sd9, 36'sd9), 32'h0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk_word("R13 mid-run word", word_out, '0);
        chk_bit("R13 mid-run spike", spike_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_memoryless();
        t_threshold();
        t_incremental();
        t_leaky();
        t_hold_model();
        t_synaptic();
        t_null();
        t_wrap();
        t_idle_hold();
        t_mid_reset();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule